// File: doc/BRIEF.md
# Stacked DRAM Activate and Mode-Register Timing Checker

This block sits beside the command path of a stacked DRAM device with several logical ranks (eight by default), each holding several banks (eight by default). It observes one decoded command per clock: a valid strobe, the command kind, the target logical rank and the bank. It never alters or stalls the stream. It judges each valid command against the activate spacing rules, the four-activate window rules and the mode-register spacing rules, all counted in clock cycles with the limits set by parameters.

The input is a valid-qualified stream with no back-pressure. There is no ready pin, because the checker accepts every beat. A beat counts only in a cycle where `cmd_vld` is high. One cycle after a beat, the block reports the result as a one-cycle pulse with a code. Every rule that involves activates is tracked per logical rank and also across the whole device. A command that breaks a rule is still recorded, so later commands are judged against the true history.

Top module: `stk_act_guard`

## Requirements
- R1: An activate (kind 0) to a bank of a logical rank that had an activate less than T_RC cycles earlier reports code 3. A gap of exactly T_RC is legal.
- R2: An activate to a logical rank whose most recent activate, to any bank, is less than T_RRD_SR cycles old reports code 4. A gap of exactly T_RRD_SR is legal.
- R3: An activate reports code 5 when any other logical rank had an activate less than T_RRD_DR cycles earlier. A gap of exactly T_RRD_DR is legal.
- R4: An activate reports code 6 when it is the fifth activate to its logical rank inside T_FAW_SR cycles. This means the fourth-newest earlier activate to that rank is less than T_FAW_SR cycles old.
- R5: An activate reports code 7 when the fourth-newest earlier activate to the device, counted across all ranks, is less than T_FAW_DR cycles old.
- R6: A mode-register-set command (kind 1) less than T_MRD cycles after the previous one reports code 2, whichever ranks the two commands target.
- R7: Any command of kind 0, 2 or 3 less than T_MOD cycles after the latest mode-register set reports code 1. Mode-register sets are exempt from this rule, and kinds 2 and 3 are subject to no other rule.
- R8: When one command breaks several rules, the lowest code is reported.
- R9: The result of a command sampled at a clock edge appears on `viol_pulse` and `viol_code` right after that edge and lasts one cycle. `viol_code` is 0 whenever `viol_pulse` is low.
- R10: A beat with `cmd_vld` low is ignored. It gives no pulse and leaves no trace in any history.
- R11: A command that triggers a violation is still entered into the histories it belongs to.
- R12: Reset clears all histories and drives both outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_vld | input | 1 | Command beat valid |
| cmd_kind | input | 2 | 0 activate, 1 mode-register set, 2 and 3 other commands |
| cmd_rank | input | $clog2(NR) | Target logical rank |
| cmd_bank | input | $clog2(NB) | Target bank |
| viol_pulse | output | 1 | One-cycle flag for a rule breach |
| viol_code | output | 3 | Code of the breached rule, 0 when none |

## Verification
Every result is due exactly one clock after the edge that samples the command, because a single output register sits between the decision logic and the pins. The bench drives each beat on a falling edge and reads the outputs at the next falling edge, which is half a cycle after that register loads. Every idle cycle between vector beats is also checked for a silent output. Those idle beats carry the next command's fields with the valid strobe low, so a history that wrongly recorded them would shift the very next verdict.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    CMD_ACT   = 2'd0,
    CMD_MRS   = 2'd1,
    CMD_RW    = 2'd2,
    CMD_OTHER = 2'd3
  } cmd_kind_e;

  // lower value wins when several rules break together
  typedef enum logic [2:0] {
    VC_NONE   = 3'd0,
    VC_MOD    = 3'd1,
    VC_MRD    = 3'd2,
    VC_RC     = 3'd3,
    VC_RRD_SR = 3'd4,
    VC_RRD_DR = 3'd5,
    VC_FAW_SR = 3'd6,
    VC_FAW_DR = 3'd7
  } viol_code_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/stk_act_window.sv
module stk_act_window #(
  parameter int AW    = 5,
  parameter int WIN   = 20,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  output logic          full_hit,
  output logic [AW-1:0] newest_age,
  output logic          newest_vld
);
  localparam logic [AW-1:0] AMAX  = '1;
  localparam logic [AW-1:0] WIN_C = AW'(WIN);

  logic [AW-1:0]    age_q [DEPTH];
  logic [DEPTH-1:0] vld_q;

  function automatic logic [AW-1:0] sat_inc(input logic [AW-1:0] a);
    return (a == AMAX) ? a : a + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) age_q[i] <= '0;
    end else if (push) begin
      vld_q    <= {vld_q[DEPTH-2:0], 1'b1};
      age_q[0] <= AW'(1);
      for (int i = 1; i < DEPTH; i++) age_q[i] <= sat_inc(age_q[i-1]);
    end else begin
      for (int i = 0; i < DEPTH; i++) age_q[i] <= sat_inc(age_q[i]);
    end
  end

  assign full_hit   = vld_q[DEPTH-1] && (age_q[DEPTH-1] < WIN_C);
  assign newest_age = age_q[0];
  assign newest_vld = vld_q[0];

  // R4
  win_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vld_q + DEPTH'(1)));

  // R11
  win_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (newest_vld && newest_age == AW'(1)));

  generate
    for (genvar g = 0; g < DEPTH - 1; g++) begin : g_ord
      // R5
      win_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q[g+1]) |-> (age_q[g] <= age_q[g+1]));
    end
  endgenerate
endmodule

// File: rtl/stk_bank_rc.sv
module stk_bank_rc #(
  parameter int NB  = 8,
  parameter int AW  = 5,
  parameter int TRC = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push,
  input  logic [$clog2(NB)-1:0] bank,
  output logic                  hit
);
  localparam logic [AW-1:0] AMAX  = '1;
  localparam logic [AW-1:0] TRC_C = AW'(TRC);

  logic [AW-1:0] age_q [NB];
  logic [NB-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int b = 0; b < NB; b++) age_q[b] <= '0;
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (push && bank == b[$clog2(NB)-1:0]) begin
          vld_q[b] <= 1'b1;
          age_q[b] <= AW'(1);
        end else if (age_q[b] != AMAX) begin
          age_q[b] <= age_q[b] + AW'(1);
        end
      end
    end
  end

  assign hit = vld_q[bank] && (age_q[bank] < TRC_C);

  // R1
  rc_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (vld_q[$past(bank)] && age_q[$past(bank)] == AW'(1)));
endmodule

// File: rtl/stk_mode_gap.sv
module stk_mode_gap #(
  parameter int AW   = 5,
  parameter int TMRD = 4,
  parameter int TMOD = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vld,
  input  logic is_mrs,
  output logic mrd_hit,
  output logic mod_hit
);
  localparam logic [AW-1:0] AMAX   = '1;
  localparam logic [AW-1:0] TMRD_C = AW'(TMRD);
  localparam logic [AW-1:0] TMOD_C = AW'(TMOD);

  logic [AW-1:0] age_q;
  logic          seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      age_q  <= '0;
    end else if (vld && is_mrs) begin
      seen_q <= 1'b1;
      age_q  <= AW'(1);
    end else if (age_q != AMAX) begin
      age_q <= age_q + AW'(1);
    end
  end

  assign mrd_hit = vld &&  is_mrs && seen_q && (age_q < TMRD_C);
  assign mod_hit = vld && !is_mrs && seen_q && (age_q < TMOD_C);

  // R6
  mrs_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && is_mrs) |=> (seen_q && age_q == AW'(1)));
endmodule

// File: rtl/stk_act_guard.sv
module stk_act_guard #(
  parameter int NR        = 8,
  parameter int NB        = 8,
  parameter int T_RC      = 12,
  parameter int T_RRD_SR  = 4,
  parameter int T_RRD_DR  = 2,
  parameter int T_FAW_SR  = 20,
  parameter int T_FAW_DR  = 24,
  parameter int T_MRD     = 4,
  parameter int T_MOD     = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_vld,
  input  logic [1:0]            cmd_kind,
  input  logic [$clog2(NR)-1:0] cmd_rank,
  input  logic [$clog2(NB)-1:0] cmd_bank,
  output logic                  viol_pulse,
  output logic [2:0]            viol_code
);
  import stk_pkg::*;

  localparam int TMAX = max_of(max_of(max_of(T_RC, T_RRD_SR), max_of(T_RRD_DR, T_FAW_SR)),
                               max_of(max_of(T_FAW_DR, T_MRD), T_MOD));
  localparam int AW = $clog2(TMAX + 1);
  localparam logic [AW-1:0] RRD_SR_C = AW'(T_RRD_SR);
  localparam logic [AW-1:0] RRD_DR_C = AW'(T_RRD_DR);

  logic is_act, is_mrs;
  assign is_act = cmd_vld && (cmd_kind == CMD_ACT);
  assign is_mrs = (cmd_kind == CMD_MRS);

  logic [NR-1:0] rk_faw, rk_rc, rk_vld;
  logic [AW-1:0] rk_age [NR];

  generate
    for (genvar r = 0; r < NR; r++) begin : g_rank
      logic push_r;
      assign push_r = is_act && (cmd_rank == r[$clog2(NR)-1:0]);

      stk_act_window #(.AW(AW), .WIN(T_FAW_SR), .DEPTH(4)) u_win (
        .clk(clk), .rst_n(rst_n), .push(push_r),
        .full_hit(rk_faw[r]), .newest_age(rk_age[r]), .newest_vld(rk_vld[r])
      );

      stk_bank_rc #(.NB(NB), .AW(AW), .TRC(T_RC)) u_rc (
        .clk(clk), .rst_n(rst_n), .push(push_r), .bank(cmd_bank), .hit(rk_rc[r])
      );
    end
  endgenerate

  logic          dev_faw, dev_vld;
  logic [AW-1:0] dev_age;

  stk_act_window #(.AW(AW), .WIN(T_FAW_DR), .DEPTH(4)) u_dev_win (
    .clk(clk), .rst_n(rst_n), .push(is_act),
    .full_hit(dev_faw), .newest_age(dev_age), .newest_vld(dev_vld)
  );

  logic mrd_hit, mod_hit;

  stk_mode_gap #(.AW(AW), .TMRD(T_MRD), .TMOD(T_MOD)) u_mode (
    .clk(clk), .rst_n(rst_n), .vld(cmd_vld), .is_mrs(is_mrs),
    .mrd_hit(mrd_hit), .mod_hit(mod_hit)
  );

  logic sr_hit, dr_hit;
  always_comb begin
    sr_hit = rk_vld[cmd_rank] && (rk_age[cmd_rank] < RRD_SR_C);
    dr_hit = 1'b0;
    for (int r = 0; r < NR; r++) begin
      if (r != int'(cmd_rank) && rk_vld[r] && rk_age[r] < RRD_DR_C) dr_hit = 1'b1;
    end
  end

  viol_code_e code_n;
  always_comb begin
    code_n = VC_NONE;
    if (mod_hit)                      code_n = VC_MOD;
    else if (mrd_hit)                 code_n = VC_MRD;
    else if (is_act) begin
      if (rk_rc[cmd_rank])            code_n = VC_RC;
      else if (sr_hit)                code_n = VC_RRD_SR;
      else if (dr_hit)                code_n = VC_RRD_DR;
      else if (rk_faw[cmd_rank])      code_n = VC_FAW_SR;
      else if (dev_faw)               code_n = VC_FAW_DR;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol_pulse <= 1'b0;
      viol_code  <= VC_NONE;
    end else begin
      viol_pulse <= (code_n != VC_NONE);
      viol_code  <= code_n;
    end
  end

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmd_vld) |-> !viol_pulse);

  // R3
  dev_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |=> (dev_vld && dev_age == AW'(1)));
endmodule

// File: tb/sim_stk_act_guard.sv
`timescale 1ns/1ps
module sim_stk_act_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_vld = 1'b0;
  logic [1:0] cmd_kind = 2'd0;
  logic [2:0] cmd_rank = 3'd0;
  logic [2:0] cmd_bank = 3'd0;
  logic       viol_pulse;
  logic [2:0] viol_code;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  stk_act_guard u0 (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_kind(cmd_kind),
    .cmd_rank(cmd_rank), .cmd_bank(cmd_bank),
    .viol_pulse(viol_pulse), .viol_code(viol_code)
  );

  // fields: kind[18:17] rank[16:14] bank[13:11] gap[10:3] expected code[2:0]
  localparam int NV = 22;
  localparam logic [18:0] VEC [NV] = '{
    {2'd0, 3'd0, 3'd0, 8'd1,  3'd0},  // first activate
    {2'd0, 3'd1, 3'd0, 8'd2,  3'd0},  // R3 exact gap; R10 idle beat on same rank
    {2'd0, 3'd2, 3'd0, 8'd1,  3'd5},  // R3
    {2'd0, 3'd0, 3'd1, 8'd2,  3'd0},  // R11 previous breach recorded, dev window 4th
    {2'd0, 3'd3, 3'd0, 8'd2,  3'd7},  // R5
    {2'd0, 3'd0, 3'd1, 8'd30, 3'd0},  // windows cleared
    {2'd0, 3'd0, 3'd1, 8'd2,  3'd3},  // R1 (R2 also broken, R8)
    {2'd0, 3'd0, 3'd2, 8'd4,  3'd0},  // R2 exact gap
    {2'd0, 3'd0, 3'd3, 8'd2,  3'd4},  // R2
    {2'd0, 3'd0, 3'd4, 8'd4,  3'd6},  // R4 (R5 also broken, R8)
    {2'd1, 3'd0, 3'd0, 8'd30, 3'd0},  // first mode set, R10 idle mode-set beats
    {2'd1, 3'd5, 3'd0, 8'd2,  3'd2},  // R6 other rank
    {2'd1, 3'd1, 3'd0, 8'd4,  3'd0},  // R6 exact gap
    {2'd2, 3'd2, 3'd0, 8'd3,  3'd1},  // R7
    {2'd0, 3'd3, 3'd0, 8'd3,  3'd1},  // R7 activate blocked
    {2'd0, 3'd4, 3'd0, 8'd6,  3'd0},  // R7 exact gap
    {2'd2, 3'd4, 3'd0, 8'd1,  3'd0},  // R7 kind 2 free
    {2'd3, 3'd7, 3'd0, 8'd1,  3'd0},  // R7 kind 3 free
    {2'd0, 3'd6, 3'd5, 8'd20, 3'd0},
    {2'd0, 3'd6, 3'd5, 8'd11, 3'd3},  // R1 one short
    {2'd0, 3'd6, 3'd5, 8'd4,  3'd3},  // R11 breach above counts
    {2'd0, 3'd6, 3'd5, 8'd12, 3'd0}   // R1 exact gap
  };

  function automatic string req_of(input logic [2:0] c);
    case (c)
      3'd1: return "R7";
      3'd2: return "R6";
      3'd3: return "R1";
      3'd4: return "R2";
      3'd5: return "R3";
      3'd6: return "R4";
      3'd7: return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input logic [2:0] exp, input string req);
    total++;
    if (viol_pulse !== (exp != 3'd0) || viol_code !== exp) begin
      bad++;
      $display("FAIL %s: pulse=%0b code=%0d expected pulse=%0b code=%0d",
               req, viol_pulse, viol_code, (exp != 3'd0), exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] k, input logic [2:0] r, input logic [2:0] b);
    cmd_vld = v; cmd_kind = k; cmd_rank = r; cmd_bank = b;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R9: watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(3'd0, "R12");                      // outputs low in reset
    rst_n = 1'b1;
    @(negedge clk);
    chk(3'd0, "R12");                      // empty history after reset
    for (int i = 0; i < NV; i++) begin
      logic [1:0] k; logic [2:0] r, b, e; logic [7:0] g;
      {k, r, b, g, e} = VEC[i];
      for (int j = 1; j < int'(g); j++) begin
        drive(1'b0, k, r, b);              // fields set, strobe low
        @(negedge clk);
        chk(3'd0, "R10");
      end
      drive(1'b1, k, r, b);
      @(negedge clk);
      chk(e, req_of(e));                   // R9 due one edge later
    end
    drive(1'b0, 2'd0, 3'd0, 3'd0);
    @(negedge clk);
    chk(3'd0, "R9");                       // pulse lasts one cycle
    // reset between two close activates to one bank
    drive(1'b1, 2'd0, 3'd0, 3'd0);
    @(negedge clk);
    drive(1'b0, 2'd0, 3'd0, 3'd0);
    rst_n = 1'b0;
    @(negedge clk);
    chk(3'd0, "R12");
    rst_n = 1'b1;
    drive(1'b1, 2'd0, 3'd0, 3'd0);
    @(negedge clk);
    chk(3'd0, "R12");                      // history cleared
    drive(1'b1, 2'd0, 3'd0, 3'd0);
    @(negedge clk);
    chk(3'd3, "R1");                       // tracking resumes
    drive(1'b0, 2'd0, 3'd0, 3'd0);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule